// File: doc/BRIEF.md
# Platform System Control Port Block

This block sits on a byte-wide I/O strobe bus and answers a small set of 16-bit port addresses used by a legacy workstation platform. It has one writable system control byte whose outer bit pairs drive cache enables. It also keeps a two-bit lock state for a non-volatile store, and each lock bit flips whenever its own port is written. Several ports return fixed identity and status bytes. Every port address this block does not decode reads as 0xFF.

Some control bits in written data are not stored. These are the soft-reset request, the little-endian request and the non-contiguous I/O map request. Each one becomes a single-cycle pulse, and downstream logic decides what to do with it. The bus has no back-pressure: the block accepts a strobe in every cycle. Read data is registered and comes with a one-cycle acknowledge. A read and a write may share a cycle. In that case the read returns the state as it was before the write.

Top module: `sysctl_port_block`

## Requirements
- R1: While reset is asserted, and after it is released, rd_data and rd_ack are 0, the control byte and both lock bits are 0, and all three request pulses are low.
- R2: rd_ack is high in exactly the cycles that follow a cycle with rd_en high. rd_data is updated in those same cycles and holds its value otherwise.
- R3: A read of any address other than 0x0092, 0x080C, 0x0818, 0x081C, 0x0823 and 0x0850 returns 0xFF.
- R4: Reads return fixed bytes at these ports: 0x0092 gives 0x40, 0x080C gives 0xFC, 0x0818 gives 0x00, 0x0823 gives 0x03 and 0x0850 gives 0x00.
- R5: A write to 0x081C stores the byte, and a later read of 0x081C returns it. cache_en is {ctrl[7], ctrl[6], ctrl[1], ctrl[0]}.
- R6: Any write to 0x0810 inverts lock_state[0], and any write to 0x0812 inverts lock_state[1], whatever the data.
- R7: A write to 0x0092 with data bit 7 set raises soft_reset_req for the one cycle after the write.
- R8: A write to 0x0092 with data bit 6 set raises little_endian_req for the one cycle after the write. Bits 7 and 6 act independently of each other.
- R9: A write to 0x0850 with data bit 7 set raises iomap_unsupported for the one cycle after the write. Other data bits raise nothing.
- R10: Writes to 0x0808, 0x0814, the fixed read-only ports and undecoded addresses change no state and raise no request.
- R11: When a read and a write of 0x081C happen in the same cycle, the read returns the old value and the new value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 16 | Port address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_ack | output | 1 | Read acknowledge, one cycle after rd_en |
| ctrl_byte | output | 8 | System control register contents |
| cache_en | output | 4 | Cache enable bits taken from the control byte |
| lock_state | output | 2 | Lock bits for the non-volatile store |
| soft_reset_req | output | 1 | Soft-reset request pulse |
| little_endian_req | output | 1 | Little-endian mode request pulse |
| iomap_unsupported | output | 1 | Non-contiguous I/O map request pulse |

## Verification
The hardest case to reach from the ports is a read and a write that land on the control register in the same cycle. To get there, the stimulus drives both strobes at 0x081C in one cycle and then compares the returned byte with the stored one. Writes that must leave state alone are checked the same way. The stimulus writes patterned data to the ignored and read-only ports, reads the control register back, and watches the lock and request outputs in every cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int PORT_ADDR_W = 16;
  localparam int PORT_DATA_W = 8;

  localparam logic [PORT_ADDR_W-1:0] A_SPECIAL = 16'h0092;
  localparam logic [PORT_ADDR_W-1:0] A_EQUIP   = 16'h080C;
  localparam logic [PORT_ADDR_W-1:0] A_LOCK0   = 16'h0810;
  localparam logic [PORT_ADDR_W-1:0] A_LOCK1   = 16'h0812;
  localparam logic [PORT_ADDR_W-1:0] A_KEYSW   = 16'h0818;
  localparam logic [PORT_ADDR_W-1:0] A_CTRL    = 16'h081C;
  localparam logic [PORT_ADDR_W-1:0] A_L2STAT  = 16'h0823;
  localparam logic [PORT_ADDR_W-1:0] A_IOMAP   = 16'h0850;

  localparam logic [PORT_DATA_W-1:0] V_SPECIAL = 8'h40;
  localparam logic [PORT_DATA_W-1:0] V_EQUIP   = 8'hFC;
  localparam logic [PORT_DATA_W-1:0] V_KEYSW   = 8'h00;
  localparam logic [PORT_DATA_W-1:0] V_L2STAT  = 8'h03;
  localparam logic [PORT_DATA_W-1:0] V_IOMAP   = 8'h00;
  localparam logic [PORT_DATA_W-1:0] V_MISS    = 8'hFF;

  localparam int LOCK_BITS = 2;

  typedef struct packed {
    logic special;
    logic equip;
    logic keysw;
    logic ctrl;
    logic l2stat;
    logic iomap;
  } rd_sel_t;

  typedef struct packed {
    logic                 special;
    logic                 ctrl;
    logic                 iomap;
    logic [LOCK_BITS-1:0] lock;
  } wr_sel_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = PORT_ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output rd_sel_t           rsel,
  output wr_sel_t           wsel
);
  localparam logic [ADDR_W-1:0] LOCK_ADDR [LOCK_BITS] = '{A_LOCK0, A_LOCK1};

  always_comb begin
    rsel.special = (addr == A_SPECIAL);
    rsel.equip   = (addr == A_EQUIP);
    rsel.keysw   = (addr == A_KEYSW);
    rsel.ctrl    = (addr == A_CTRL);
    rsel.l2stat  = (addr == A_L2STAT);
    rsel.iomap   = (addr == A_IOMAP);
  end

  assign wsel.special = (addr == A_SPECIAL);
  assign wsel.ctrl    = (addr == A_CTRL);
  assign wsel.iomap   = (addr == A_IOMAP);

  for (genvar gi = 0; gi < LOCK_BITS; gi++) begin : g_lock_dec
    assign wsel.lock[gi] = (addr == LOCK_ADDR[gi]);
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int DATA_W = PORT_DATA_W,
  parameter int NLOCK  = LOCK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sel_ctrl,
  input  logic [NLOCK-1:0]  sel_lock,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [NLOCK-1:0]  lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (wr_en && sel_ctrl) ctrl_q <= wr_data;
  end

  for (genvar gi = 0; gi < NLOCK; gi++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    lock_q[gi] <= 1'b0;
      else if (wr_en && sel_lock[gi]) lock_q[gi] <= ~lock_q[gi];
    end

    // R6
    lock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_lock[gi]) |=> (lock_q[gi] != $past(lock_q[gi])));

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel_lock[gi]) |=> $stable(lock_q[gi]));
  end

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/sysctl_reqgen.sv
module sysctl_reqgen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] top_bits,
  input  logic       sel_special,
  input  logic       sel_iomap,
  output logic       srst_q,
  output logic       le_q,
  output logic       iomap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b0;
      le_q    <= 1'b0;
      iomap_q <= 1'b0;
    end else begin
      srst_q  <= wr_en && sel_special && top_bits[1];
      le_q    <= wr_en && sel_special && top_bits[0];
      iomap_q <= wr_en && sel_iomap && top_bits[1];
    end
  end

  // R7
  srst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> $past(wr_en));

  // R8
  le_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_q |-> $past(wr_en));

  // R9
  iomap_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_iomap && top_bits[1]) |=> iomap_q);

  // R10
  no_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !(srst_q || le_q || iomap_q));
endmodule

// File: rtl/sysctl_readmux.sv
module sysctl_readmux
  import sysctl_pkg::*;
#(
  parameter int DATA_W = PORT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  rd_sel_t           rsel,
  input  logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack
);
  logic [DATA_W-1:0] rd_next;
  logic              hit;

  assign hit = |rsel;

  always_comb begin
    rd_next = V_MISS;
    if (rsel.special)     rd_next = V_SPECIAL;
    else if (rsel.equip)  rd_next = V_EQUIP;
    else if (rsel.keysw)  rd_next = V_KEYSW;
    else if (rsel.ctrl)   rd_next = ctrl_q;
    else if (rsel.l2stat) rd_next = V_L2STAT;
    else if (rsel.iomap)  rd_next = V_IOMAP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R2
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_ack);

  // R2
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_ack);

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R3
  miss_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rd_data == V_MISS));

  // R11
  old_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rsel.ctrl) |=> (rd_data == $past(ctrl_q)));

  sel_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsel));
endmodule

// File: rtl/sysctl_port_block.sv
module sysctl_port_block
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = PORT_ADDR_W,
  parameter int DATA_W = PORT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack,
  output logic [DATA_W-1:0] ctrl_byte,
  output logic [3:0]        cache_en,
  output logic [1:0]        lock_state,
  output logic              soft_reset_req,
  output logic              little_endian_req,
  output logic              iomap_unsupported
);
  localparam int TOP = DATA_W - 1;

  rd_sel_t           rsel;
  wr_sel_t           wsel;
  logic [DATA_W-1:0] ctrl_q;
  logic [LOCK_BITS-1:0] lock_q;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .rsel (rsel),
    .wsel (wsel)
  );

  sysctl_regs #(.DATA_W(DATA_W), .NLOCK(LOCK_BITS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sel_ctrl (wsel.ctrl),
    .sel_lock (wsel.lock),
    .ctrl_q   (ctrl_q),
    .lock_q   (lock_q)
  );

  sysctl_reqgen u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .top_bits    (wr_data[TOP -: 2]),
    .sel_special (wsel.special),
    .sel_iomap   (wsel.iomap),
    .srst_q      (soft_reset_req),
    .le_q        (little_endian_req),
    .iomap_q     (iomap_unsupported)
  );

  sysctl_readmux #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rsel    (rsel),
    .ctrl_q  (ctrl_q),
    .rd_data (rd_data),
    .rd_ack  (rd_ack)
  );

  assign ctrl_byte  = ctrl_q;
  assign lock_state = lock_q;
  assign cache_en   = {ctrl_q[TOP], ctrl_q[TOP-1], ctrl_q[1], ctrl_q[0]};
endmodule

// File: tb/sysctl_port_block_tb_top.sv
module sysctl_port_block_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        rd_ack;
  logic [7:0]  ctrl_byte;
  logic [3:0]  cache_en;
  logic [1:0]  lock_state;
  logic        soft_reset_req, little_endian_req, iomap_unsupported;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] m_rdata = 8'h00, m_ctrl = 8'h00;
  logic       m_ack = 1'b0, m_srst = 1'b0, m_le = 1'b0, m_iomap = 1'b0;
  logic [1:0] m_lock = 2'b00;

  always #4 clk = ~clk;

  sysctl_port_block dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_ack(rd_ack),
    .ctrl_byte(ctrl_byte), .cache_en(cache_en), .lock_state(lock_state),
    .soft_reset_req(soft_reset_req), .little_endian_req(little_endian_req),
    .iomap_unsupported(iomap_unsupported)
  );

  function automatic logic [7:0] port_value(input logic [15:0] a);
    case (a)
      16'h0092: return 8'h40;
      16'h080C: return 8'hFC;
      16'h0818: return 8'h00;
      16'h081C: return m_ctrl;
      16'h0823: return 8'h03;
      16'h0850: return 8'h00;
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "rd_data", rd_data, m_rdata);
    check(tag, "rd_ack", {7'd0, rd_ack}, {7'd0, m_ack});
    check(tag, "ctrl_byte", ctrl_byte, m_ctrl);
    check(tag, "cache_en", {4'd0, cache_en},
          {4'd0, m_ctrl[7], m_ctrl[6], m_ctrl[1], m_ctrl[0]});
    check(tag, "lock_state", {6'd0, lock_state}, {6'd0, m_lock});
    check(tag, "soft_reset_req", {7'd0, soft_reset_req}, {7'd0, m_srst});
    check(tag, "little_endian_req", {7'd0, little_endian_req}, {7'd0, m_le});
    check(tag, "iomap_unsupported", {7'd0, iomap_unsupported}, {7'd0, m_iomap});
  endtask

  task automatic cyc(input string tag, input logic r, input logic w,
                     input logic [15:0] a, input logic [7:0] d);
    logic [7:0] rv;
    rd_en = r; wr_en = w; addr = a; wr_data = d;
    @(posedge clk);
    rv = port_value(a);
    m_ack   = r;
    if (r) m_rdata = rv;
    m_srst  = w && a == 16'h0092 && d[7];
    m_le    = w && a == 16'h0092 && d[6];
    m_iomap = w && a == 16'h0850 && d[7];
    if (w && a == 16'h081C) m_ctrl = d;
    if (w && a == 16'h0810) m_lock[0] = ~m_lock[0];
    if (w && a == 16'h0812) m_lock[1] = ~m_lock[1];
    #2;
    compare_all(tag);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare_all("R1");
    rst_n = 1'b1;
    #2;
    compare_all("R1");

    // R4 fixed bytes, R2 ack timing
    cyc("R4", 1, 0, 16'h0092, 8'h00);
    cyc("R4", 1, 0, 16'h080C, 8'h00);
    cyc("R4", 1, 0, 16'h0818, 8'h00);
    cyc("R4", 1, 0, 16'h0823, 8'h00);
    cyc("R4", 1, 0, 16'h0850, 8'h00);
    cyc("R2", 0, 0, 16'h0823, 8'h00);
    cyc("R2", 0, 0, 16'h0000, 8'h00);
    // R3 undecoded
    cyc("R3", 1, 0, 16'h0000, 8'h00);
    cyc("R3", 1, 0, 16'h0093, 8'h00);
    cyc("R3", 1, 0, 16'h081D, 8'h00);
    cyc("R3", 1, 0, 16'h0810, 8'h00);
    cyc("R3", 1, 0, 16'hFFFF, 8'h00);
    cyc("R2", 0, 0, 16'h0092, 8'h00);
    // R5 control register
    cyc("R5", 0, 1, 16'h081C, 8'hC3);
    cyc("R5", 1, 0, 16'h081C, 8'h00);
    cyc("R5", 0, 1, 16'h081C, 8'h3C);
    cyc("R5", 1, 0, 16'h081C, 8'h00);
    cyc("R5", 0, 1, 16'h081C, 8'h81);
    // R6 lock toggles
    cyc("R6", 0, 1, 16'h0810, 8'h00);
    cyc("R6", 0, 1, 16'h0812, 8'hFF);
    cyc("R6", 0, 1, 16'h0810, 8'h5A);
    cyc("R6", 0, 1, 16'h0812, 8'h00);
    cyc("R6", 0, 1, 16'h0812, 8'h00);
    // R7 / R8 request pulses
    cyc("R7", 0, 1, 16'h0092, 8'h80);
    cyc("R7", 0, 0, 16'h0092, 8'h80);
    cyc("R8", 0, 1, 16'h0092, 8'h40);
    cyc("R8", 0, 0, 16'h0092, 8'h40);
    cyc("R8", 0, 1, 16'h0092, 8'hC0);
    cyc("R8", 0, 1, 16'h0092, 8'h3F);
    // R9 I/O map
    cyc("R9", 0, 1, 16'h0850, 8'h80);
    cyc("R9", 0, 1, 16'h0850, 8'h7F);
    cyc("R9", 0, 1, 16'h0850, 8'hFF);
    cyc("R9", 0, 0, 16'h0850, 8'h00);
    // R10 ignored writes
    cyc("R10", 0, 1, 16'h0808, 8'hA5);
    cyc("R10", 0, 1, 16'h0814, 8'hFF);
    cyc("R10", 0, 1, 16'h080C, 8'hC0);
    cyc("R10", 0, 1, 16'h0818, 8'h80);
    cyc("R10", 0, 1, 16'h0823, 8'hFF);
    cyc("R10", 0, 1, 16'h0000, 8'hFF);
    cyc("R10", 0, 1, 16'h0892, 8'hC0);
    cyc("R10", 1, 0, 16'h081C, 8'h00);
    cyc("R10", 1, 0, 16'h0092, 8'h00);
    // R11 same-cycle read and write
    cyc("R11", 1, 1, 16'h081C, 8'h55);
    cyc("R11", 1, 1, 16'h081C, 8'hAA);
    cyc("R11", 1, 0, 16'h081C, 8'h00);
    cyc("R11", 1, 1, 16'h0810, 8'h00);
    cyc("R2", 0, 0, 16'h0000, 8'h00);
    // R1 reset again mid-run
    rst_n = 1'b0;
    m_ctrl = 8'h00; m_lock = 2'b00; m_rdata = 8'h00; m_ack = 1'b0;
    m_srst = 1'b0; m_le = 1'b0; m_iomap = 1'b0;
    #2;
    compare_all("R1");
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    cyc("R1", 1, 0, 16'h081C, 8'h00);
    finish_run();
  end
endmodule